// File: doc/BRIEF.md
# Glitch-Free Power-of-Two Clock Prescaler

This block takes a free-running master clock and delivers a copy of it divided by a power of two, 2^x, where x comes from a 4-bit divide code. The block gates the divided clock onto the output pin. It opens and closes that gate only while the divided clock is low, so the pin never shows a shortened pulse. When output enable is low, the output sits low but stays driven. The divider keeps running during that time, so re-enabling is quick and always takes the same time.

A power-down input stops the output. A power-down request counts only after it has stayed low for two full output periods. Once accepted, the block lets the current period finish, then stops the divider and releases the output drive for high impedance. After reset, and again after power-down ends, the block holds the output low for a fixed stabilisation count of master cycles before the first edge.

The control is a four-state machine:
- **WARM** counts the stabilisation cycles.
- **RUN** gates the clock according to output enable.
- **DRAIN** waits for the gate to close after a power-down has been accepted.
- **OFF** holds the divider and releases the drive.

The transitions are:
- reset enters WARM.
- WARM goes to RUN when the stabilisation count ends.
- WARM goes straight to OFF on an accepted power-down.
- RUN goes to DRAIN on an accepted power-down.
- DRAIN goes to OFF once the gate is shut.
- OFF goes to WARM when the synchronised power input returns high.

Top module: `pow2_clk_prescaler`

## Requirements
- R1: With an effective exponent x from 0 to 8, clk_out has a period of 2^x master cycles. For x of 1 or more it is low for the first half of each period and high for the second half. For x = 0 it follows the master clock.
- R2: A divide code above 8 (codes 9 to 15) acts exactly like code 8, a divide by 256.
- R3: After reset is released, clk_out stays low while out_drive is high. The first rising edge comes exactly 512 + h master rising edges after release, where h = max(1, 2^(x-1)).
- R4: While oe_in is low, clk_out stays low and out_drive stays high.
- R5: oe_in passes through two flops. Let P be the master rising edge that first samples oe_in high after it rose with the gate shut. The first rising edge of clk_out then comes at edge P + 2 + h. The divider restarts at that moment, so this latency never depends on phase.
- R6: The gate opens and closes only at a period boundary, where the divided clock is low. After oe_in falls, the pulse in progress completes at its full high width.
- R7: pwr_on passes through two flops. A low on pwr_on lasting fewer than 2·2^x master cycles is ignored: out_drive stays high and the output keeps its period.
- R8: A low on pwr_on lasting at least 2·2^x master cycles is accepted. The current period then ends, clk_out is held low, and out_drive goes low.
- R9: When pwr_on returns high after an accepted power-down, out_drive goes high again. The 512-cycle stabilisation then runs again, and the first edge follows the timing of R3 counted from the reopening.
- R10: A change of div_code takes effect at the next period boundary. Within one old period, the output runs at the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_code | input | 4 | Divide exponent; values above 8 saturate at 8 |
| oe_in | input | 1 | Output enable, asynchronous, active high |
| pwr_on | input | 1 | Low requests power-down, asynchronous |
| clk_out | output | 1 | Gated, divided clock |
| out_drive | output | 1 | High while clk_out should be driven; low for high impedance |

## Verification
The bench measures the exact time of the first output edge after reset, after oe_in rises and after power-down ends. A design that counted the stabilisation window wrongly, or did not restart the divider on enable, would put that edge at a different time. It drops oe_in in the middle of a high pulse. A design that closed the gate at once would then show a short pulse. It sends a power-down glitch two cycles shorter than the acceptance window. A filter with an off-by-one would then wrongly release the drive. It checks that codes 12 and 15 give the same period as code 8, and that a code change from divide-by-256 settles within one old period. A design that let codes wrap or applied a new code mid-period would break these checks.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        ST_WARM  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_OFF   = 2'd3
    } pstate_e;

endpackage

// File: rtl/pclk_sync2.sv
module pclk_sync2 #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end

endmodule

// File: rtl/pclk_div.sv
module pclk_div #(
    parameter int MAX_EXP = 8,
    parameter int CODE_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hold,
    input  logic                              restart,
    input  logic [CODE_W-1:0]                 code,
    output logic                              div_q,
    output logic                              wrap,
    output logic [$clog2(MAX_EXP+1)-1:0]      x_act
);

    localparam int EXP_W = $clog2(MAX_EXP + 1);
    localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] half;
    logic [EXP_W-1:0] x_new;

    always_comb begin
        x_new = (code > CODE_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : EXP_W'(code);
        last  = CNT_W'((32'd1 << x_act) - 32'd1);
        half  = (x_act == '0) ? CNT_W'(1) : CNT_W'(32'd1 << (x_act - 1'b1));
        wrap  = (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= 1'b0;
            x_act <= '0;
        end else if (hold || restart || wrap) begin
            cnt   <= '0;
            div_q <= 1'b0;
            x_act <= x_new;
        end else begin
            cnt   <= cnt + 1'b1;
            div_q <= (x_act != '0) && ((cnt + 1'b1) >= half);
        end
    end

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    p_exp_saturated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        x_act <= EXP_W'(MAX_EXP));

    p_exp_held_mid_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !restart && !wrap) |=> $stable(x_act));

endmodule

// File: rtl/pclk_pdflt.sv
module pclk_pdflt #(
    parameter int MAX_EXP    = 8,
    parameter int PD_PERIODS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arm,
    input  logic                          pwr_s,
    input  logic [$clog2(MAX_EXP+1)-1:0]  x_act,
    output logic                          pd_hit
);

    localparam int PD_W = $clog2(PD_PERIODS) + MAX_EXP + 1;

    logic [PD_W-1:0] pd_cnt;
    logic [PD_W-1:0] thr;

    always_comb begin
        thr    = PD_W'(PD_PERIODS) << x_act;
        pd_hit = arm && !pwr_s && (pd_cnt >= thr - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_cnt <= '0;
        end else if (arm && !pwr_s) begin
            if (pd_cnt != thr) pd_cnt <= pd_cnt + 1'b1;
        end else begin
            pd_cnt <= '0;
        end
    end

    p_hit_needs_prior_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_hit |-> !$past(pwr_s));

endmodule

// File: rtl/pow2_clk_prescaler.sv
module pow2_clk_prescaler #(
    parameter int MAX_EXP     = 8,
    parameter int CODE_W      = 4,
    parameter int STAB_CYCLES = 512,
    parameter int PD_PERIODS  = 2
) (
    input  logic              clk_m,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] div_code,
    input  logic              oe_in,
    input  logic              pwr_on,
    output logic              clk_out,
    output logic              out_drive
);

    import pclk_pkg::*;

    localparam int EXP_W  = $clog2(MAX_EXP + 1);
    localparam int WARM_W = $clog2(STAB_CYCLES);

    pstate_e           state_q, state_d;
    logic              oe_s, pwr_s;
    logic              pd_hit, hold, restart;
    logic              div_q, wrap;
    logic [EXP_W-1:0]  x_act;
    logic [WARM_W-1:0] warm_cnt;
    logic              warm_done;
    logic              gate_q, gate_n, byp_n;

    pclk_sync2 #(.RST_VAL(1'b0)) u_oe_sync (
        .clk(clk_m), .rst_n(rst_n), .d(oe_in), .q(oe_s)
    );

    pclk_sync2 #(.RST_VAL(1'b1)) u_pwr_sync (
        .clk(clk_m), .rst_n(rst_n), .d(pwr_on), .q(pwr_s)
    );

    pclk_div #(.MAX_EXP(MAX_EXP), .CODE_W(CODE_W)) u_div (
        .clk(clk_m), .rst_n(rst_n), .hold(hold), .restart(restart),
        .code(div_code), .div_q(div_q), .wrap(wrap), .x_act(x_act)
    );

    pclk_pdflt #(.MAX_EXP(MAX_EXP), .PD_PERIODS(PD_PERIODS)) u_pdflt (
        .clk(clk_m), .rst_n(rst_n), .arm(state_q != ST_OFF),
        .pwr_s(pwr_s), .x_act(x_act), .pd_hit(pd_hit)
    );

    // state register
    always_ff @(posedge clk_m or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WARM;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WARM:  if (pd_hit) state_d = ST_OFF;
                      else if (warm_done) state_d = ST_RUN;
            ST_RUN:   if (pd_hit) state_d = ST_DRAIN;
            ST_DRAIN: if (!gate_q) state_d = ST_OFF;
            ST_OFF:   if (pwr_s) state_d = ST_WARM;
        endcase
    end

    // state outputs
    always_comb begin
        hold      = (state_q == ST_OFF);
        restart   = (state_q == ST_RUN) && !gate_q && oe_s;
        out_drive = (state_q != ST_OFF);
        warm_done = (warm_cnt == WARM_W'(STAB_CYCLES - 1));
    end

    always_ff @(posedge clk_m or negedge rst_n) begin
        if (!rst_n)                  warm_cnt <= '0;
        else if (state_q != ST_WARM) warm_cnt <= '0;
        else                         warm_cnt <= warm_cnt + 1'b1;
    end

    // gate moves only at a restart or a period boundary, where div_q is low
    always_ff @(posedge clk_m or negedge rst_n) begin
        if (!rst_n)
            gate_q <= 1'b0;
        else if (restart)
            gate_q <= 1'b1;
        else if (gate_q && wrap && !((state_q == ST_RUN) && oe_s))
            gate_q <= 1'b0;
    end

    // retimed onto the falling edge so the bypass path never chops a high phase
    always_ff @(negedge clk_m or negedge rst_n) begin
        if (!rst_n) begin
            gate_n <= 1'b0;
            byp_n  <= 1'b0;
        end else begin
            gate_n <= gate_q;
            byp_n  <= (x_act == '0);
        end
    end

    assign clk_out = gate_n & (byp_n ? clk_m : div_q);

    p_gate_moves_low_r6: assert property (@(posedge clk_m) disable iff (!rst_n)
        (gate_q != $past(gate_q)) |-> !div_q);

    p_dark_while_warm_r3: assert property (@(posedge clk_m) disable iff (!rst_n)
        (state_q == ST_WARM) |-> !gate_q);

    p_drain_after_low_r7: assert property (@(posedge clk_m) disable iff (!rst_n)
        (state_q == ST_DRAIN && $past(state_q) == ST_RUN) |-> !$past(pwr_s));

    p_off_gate_shut_r8: assert property (@(posedge clk_m) disable iff (!rst_n)
        (state_q == ST_OFF) |-> !gate_n);

endmodule

// File: tb/sim_pow2_clk_prescaler.sv
module sim_pow2_clk_prescaler;

    logic       clk_m = 1'b0;
    logic       rst_n = 1'b1;
    logic [3:0] div_code = 4'd3;
    logic       oe_in = 1'b1;
    logic       pwr_on = 1'b1;
    logic       clk_out;
    logic       out_drive;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // scoreboard queues: expected rise-to-rise period in ns and its tag
    longint exp_q[$];
    string  tag_q[$];
    bit     have_last = 1'b0;
    longint last_rise_t = 0;
    int     rise_cnt = 0;
    bit     drive_low_seen = 1'b0;

    always #5 clk_m = ~clk_m;

    pow2_clk_prescaler u0 (
        .clk_m(clk_m), .rst_n(rst_n), .div_code(div_code),
        .oe_in(oe_in), .pwr_on(pwr_on),
        .clk_out(clk_out), .out_drive(out_drive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // monitor: pops one expected period per measured rise
    always @(posedge clk_out) begin
        longint t;
        t = $time;
        if (have_last && exp_q.size() > 0) begin
            longint e;
            string  g;
            e = exp_q.pop_front();
            g = tag_q.pop_front();
            chk((t - last_rise_t) == e, g, "period_ns", t - last_rise_t, e);
        end
        last_rise_t = t;
        have_last   = 1'b1;
        rise_cnt++;
    end

    always @(negedge clk_m) if (!out_drive) drive_low_seen = 1'b1;

    task automatic wait_rise(output longint t);
        int n0;
        n0 = rise_cnt;
        wait (rise_cnt != n0);
        t = last_rise_t;
    endtask

    task automatic per_chk(input int code, input longint exp_ns,
                           input string req, input int settle);
        div_code = 4'(code);
        repeat (settle) @(posedge clk_m);
        #1;
        have_last = 1'b0;
        exp_q.push_back(exp_ns); tag_q.push_back(req);
        exp_q.push_back(exp_ns); tag_q.push_back(req);
        for (int i = 0; i < 8000 && exp_q.size() > 0; i++) @(posedge clk_m);
        chk(exp_q.size() == 0, req, "pending_periods", exp_q.size(), 0);
        exp_q.delete(); tag_q.delete();
    endtask

    function automatic longint half_of(input int x);
        return (x == 0) ? 1 : (longint'(1) << (x - 1));
    endfunction

    initial begin
        repeat (150000) @(posedge clk_m);
        n_chk++; n_err++;
        $display("FAIL ALL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        longint t, tp;
        int n0;
        #1 rst_n = 1'b0;
        #49;
        // R3: reset state
        chk(clk_out == 1'b0, "R3", "clk_out_in_reset", clk_out, 0);
        chk(out_drive == 1'b1, "R3", "drive_in_reset", out_drive, 1);
        #52 rst_n = 1'b1;               // t=102, first edge after release at 105
        wait_rise(t);
        chk(t == 105 + (512 + half_of(3)) * 10, "R3", "first_rise_ns", t,
            105 + (512 + half_of(3)) * 10);

        // R1: periods across exponents
        per_chk(3, 80, "R1", 5);
        per_chk(0, 10, "R1", 600);
        per_chk(1, 20, "R1", 600);
        per_chk(5, 320, "R1", 600);
        per_chk(8, 2560, "R1", 600);
        // R2: saturation
        per_chk(12, 2560, "R2", 600);
        per_chk(15, 2560, "R2", 600);
        // R10: code change from divide-by-256 settles within one old period
        per_chk(2, 40, "R10", 300);

        // R6: dropping enable mid-pulse completes the pulse
        per_chk(4, 160, "R1", 600);
        wait_rise(t);
        #1 oe_in = 1'b0;
        wait (clk_out == 1'b0);
        chk(($time - t) == 80, "R6", "last_high_ns", $time - t, 80);

        // R4: enable low holds output low, still driven
        repeat (20) @(posedge clk_m);
        n0 = rise_cnt;
        repeat (100) @(posedge clk_m);
        #2;
        chk(rise_cnt == n0, "R4", "rises_while_disabled", rise_cnt - n0, 0);
        chk(out_drive == 1'b1, "R4", "drive_while_disabled", out_drive, 1);

        // R5: fixed enable latency, two phases, two exponents
        div_code = 4'd2;
        repeat (23) @(posedge clk_m);
        @(posedge clk_m); #1 oe_in = 1'b1; tp = $time - 1;
        wait_rise(t);
        chk(t - tp == (3 + half_of(2)) * 10, "R5", "latency_x2_a", t - tp, (3 + half_of(2)) * 10);
        #1 oe_in = 1'b0;
        repeat (37) @(posedge clk_m);
        @(posedge clk_m); #1 oe_in = 1'b1; tp = $time - 1;
        wait_rise(t);
        chk(t - tp == (3 + half_of(2)) * 10, "R5", "latency_x2_b", t - tp, (3 + half_of(2)) * 10);
        #1 oe_in = 1'b0;
        div_code = 4'd0;
        repeat (41) @(posedge clk_m);
        @(posedge clk_m); #1 oe_in = 1'b1; tp = $time - 1;
        wait_rise(t);
        chk(t - tp == (3 + half_of(0)) * 10, "R5", "latency_x0", t - tp, (3 + half_of(0)) * 10);

        // R7: glitch shorter than two output periods (8 cycles at x=2) ignored
        div_code = 4'd2;
        repeat (30) @(posedge clk_m);
        drive_low_seen = 1'b0;
        @(posedge clk_m); #1 pwr_on = 1'b0;
        repeat (6) @(posedge clk_m);
        #1 pwr_on = 1'b1;
        repeat (20) @(posedge clk_m);
        chk(drive_low_seen == 1'b0, "R7", "drive_dropped_on_glitch", drive_low_seen, 0);
        per_chk(2, 40, "R7", 2);

        // R8: sustained power-down accepted
        @(posedge clk_m); #1 pwr_on = 1'b0;
        repeat (30) @(posedge clk_m);
        #2;
        chk(out_drive == 1'b0, "R8", "drive_in_powerdown", out_drive, 0);
        chk(clk_out == 1'b0, "R8", "clk_in_powerdown", clk_out, 0);
        n0 = rise_cnt;
        repeat (50) @(posedge clk_m);
        chk(rise_cnt == n0, "R8", "rises_in_powerdown", rise_cnt - n0, 0);

        // R9: exit restarts stabilisation
        @(posedge clk_m); #1 pwr_on = 1'b1; tp = $time - 1;
        repeat (5) @(posedge clk_m);
        #2;
        chk(out_drive == 1'b1, "R9", "drive_after_exit", out_drive, 1);
        wait_rise(t);
        chk(t - tp == (515 + 1 + half_of(2)) * 10, "R9", "first_rise_after_exit",
            t - tp, (515 + 1 + half_of(2)) * 10);

        finish_run();
    end

endmodule